// File: doc/BRIEF.md
# Split-Read Cycle Counter with Tear Detection

This block keeps a wide free-running cycle counter that software reads as two 32-bit halves through an auxiliary register port. Two separate accesses cannot sample the counter at one instant. The block therefore watches each readout sequence. The sequence is a low-half read, any number of other cycles, and then a high-half read. The block records whether the high half moved in that window, and whether the core took an interrupt or an exception in it.

After the high half is read, software reads the control register. Its top bit says whether the two halves just read belong to the same 64-bit value. If the bit is clear, software repeats low, high, control until the bit is set. The counter advances once per core clock while enabled. It keeps its value while disabled, and only reset returns it to zero. The half width is a parameter, so a narrow counter can be used to exercise carries between the halves often.

Top module: `aux_ctr64`

## Requirements
- R1: After synchronous reset the count is zero, the enable is 0 and the status is 0, so the control, low and high registers all read as 0.
- R2: A write to the control register (address 0x103) loads data bit 0 into the enable. Control bit 0 reads back the enable.
- R3: While enabled, the count rises by exactly one on every clock edge, beginning with the edge after the enabling write. It wraps modulo 2^(2*HALF_W).
- R4: While disabled, the count holds its value.
- R5: Read data is combinational and zero-extended to 32 bits. Address 0x104 returns the low HALF_W bits and 0x105 returns the high HALF_W bits of the present count. Control returns the status in bit 31 and the enable in bit 0, with all other bits 0. Unmapped addresses, and any cycle without a read strobe, return 0.
- R6: Writes to the low and high addresses have no effect on the count.
- R7: A low-half read clears the status and begins a new tracking sequence, which discards any earlier violation.
- R8: A high-half read that follows a low-half read with no violation sets the status, seen from the next cycle.
- R9: If the exception/interrupt input is high in any cycle from the low read through the high read, both included, the status after that high read is 0.
- R10: If the high half of the count changes between the low-read cycle and the high-read cycle, the status after that high read is 0.
- R11: A high-half read with no pending low read leaves the status 0. Control reads do not change the tracking state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the counter advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| aux_addr | input | 12 | Auxiliary register address |
| aux_rd | input | 1 | Read strobe for the current cycle |
| aux_wr | input | 1 | Write strobe for the current cycle |
| aux_wdata | input | 32 | Write data |
| exc_taken | input | 1 | High in a cycle where an interrupt or exception is taken |
| aux_rdata | output | 32 | Read data, valid in the cycle of the read strobe |

## Verification
Register read data is due in the same cycle as the read strobe. The bench drives each access on the falling edge and samples 1 ns later, before the next rising edge. The count moves on each rising edge, from the first edge after the enabling write. The bench's arithmetic count model steps at that same edge, so each expected half comes from the model value held during the read cycle. The status is registered at the edge that ends the high-read cycle, so the bench checks it with a control read in the following cycle. The bench sweeps the gaps between the low and high reads, the position of an exception pulse and the phase of the counter against the carry, on a 4-bit-half counter. Its expected status comes only from comparing the model's high half at the two read cycles and from whether a pulse was placed in the window.

// File: rtl/ctr64_pkg.sv
package ctr64_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned AUX_AW = 12;

    localparam logic [AUX_AW-1:0] ADR_CTRL = 12'h103;
    localparam logic [AUX_AW-1:0] ADR_LO   = 12'h104;
    localparam logic [AUX_AW-1:0] ADR_HI   = 12'h105;

    localparam int unsigned STATUS_BIT = DATA_W - 1;
    localparam int unsigned ENABLE_BIT = 0;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic lo_rd;
        logic hi_rd;
        logic ctrl_rd;
        logic ctrl_wr;
        logic ctrl_val;
    } access_t;

    function automatic logic addr_hit(input logic [AUX_AW-1:0] a,
                                      input logic [AUX_AW-1:0] target);
        return a == target;
    endfunction

endpackage

// File: rtl/aux_decode.sv
module aux_decode
    import ctr64_pkg::*;
(
    input  logic [AUX_AW-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              wbit0,
    output access_t           acc
);

    always_comb begin
        acc          = '0;
        acc.lo_rd    = rd && addr_hit(addr, ADR_LO);
        acc.hi_rd    = rd && addr_hit(addr, ADR_HI);
        acc.ctrl_rd  = rd && addr_hit(addr, ADR_CTRL);
        acc.ctrl_wr  = wr && addr_hit(addr, ADR_CTRL);
        acc.ctrl_val = wbit0;
    end

endmodule

// File: rtl/ctr_core.sv
module ctr_core #(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_wr,
    input  logic             en_val,
    output logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             carry
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= 1'b0;
        end else if (en_wr) begin
            en <= en_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The coming edge moves the high half when the low half is all ones.
    assign carry = en && (&cnt[HALF_W-1:0]);

endmodule

// File: rtl/atomic_tracker.sv
module atomic_tracker
    import ctr64_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lo_rd,
    input  logic hi_rd,
    input  logic exc,
    input  logic carry,
    output logic status
);

    trk_state_e state;
    logic       viol;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TRK_IDLE;
            viol   <= 1'b0;
            status <= 1'b0;
        end else if (lo_rd) begin
            state  <= TRK_ARMED;
            viol   <= exc | carry;
            status <= 1'b0;
        end else if (hi_rd) begin
            state  <= TRK_IDLE;
            viol   <= 1'b0;
            status <= (state == TRK_ARMED) && !viol && !exc;
        end else if (state == TRK_ARMED) begin
            viol   <= viol | exc | carry;
        end
    end

endmodule

// File: rtl/aux_ctr64.sv
module aux_ctr64
    import ctr64_pkg::*;
#(
    parameter int unsigned HALF_W = 32,
    localparam int unsigned CNT_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [11:0]       aux_addr,
    input  logic              aux_rd,
    input  logic              aux_wr,
    input  logic [31:0]       aux_wdata,
    input  logic              exc_taken,
    output logic [31:0]       aux_rdata
);

    access_t          acc;
    logic             lo_rd;
    logic             hi_rd;
    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    logic             carry;
    logic             status_q;
    logic             unused_wdata;

    assign unused_wdata = ^aux_wdata[DATA_W-1:1];

    aux_decode u_dec (
        .addr  (aux_addr),
        .rd    (aux_rd),
        .wr    (aux_wr),
        .wbit0 (aux_wdata[0]),
        .acc   (acc)
    );

    assign lo_rd = acc.lo_rd;
    assign hi_rd = acc.hi_rd;

    ctr_core #(.HALF_W(HALF_W)) u_core (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (acc.ctrl_wr),
        .en_val (acc.ctrl_val),
        .en     (en_q),
        .cnt    (cnt_q),
        .carry  (carry)
    );

    atomic_tracker u_trk (
        .clk    (clk),
        .rst    (rst),
        .lo_rd  (lo_rd),
        .hi_rd  (hi_rd),
        .exc    (exc_taken),
        .carry  (carry),
        .status (status_q)
    );

    always_comb begin
        aux_rdata = '0;
        if (acc.ctrl_rd) begin
            aux_rdata[STATUS_BIT] = status_q;
            aux_rdata[ENABLE_BIT] = en_q;
        end else if (lo_rd) begin
            aux_rdata[HALF_W-1:0] = cnt_q[HALF_W-1:0];
        end else if (hi_rd) begin
            aux_rdata[HALF_W-1:0] = cnt_q[CNT_W-1:HALF_W];
        end
    end

endmodule

// File: rtl/ctr_atomic_chk.sv
module ctr_atomic_chk #(
    parameter int unsigned CNT_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [CNT_W-1:0] cnt,
    input logic             lo_rd,
    input logic             hi_rd,
    input logic             exc,
    input logic             status
);

    p_step_on_r3: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == $past(cnt) + 1'b1);

    p_hold_off_r4: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

    p_lo_clears_r7: assert property (@(posedge clk) disable iff (rst)
        lo_rd |=> !status);

    p_rise_after_hi_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(status) |-> $past(hi_rd));

    p_exc_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (hi_rd && exc) |=> !status);

    p_single_read_r5: assert property (@(posedge clk) disable iff (rst)
        !(lo_rd && hi_rd));

endmodule

bind aux_ctr64 ctr_atomic_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (en_q),
    .cnt    (cnt_q),
    .lo_rd  (lo_rd),
    .hi_rd  (hi_rd),
    .exc    (exc_taken),
    .status (status_q)
);

// File: tb/test_aux_ctr64.sv
module test_aux_ctr64;

    localparam int unsigned TH = 4;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] aux_addr = '0;
    logic        aux_rd = 1'b0;
    logic        aux_wr = 1'b0;
    logic [31:0] aux_wdata = '0;
    logic        exc_taken = 1'b0;
    logic [31:0] aux_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [2*TH-1:0] m_cnt = '0;
    logic            m_en  = 1'b0;

    always #5 clk = ~clk;

    aux_ctr64 #(.HALF_W(TH)) i_aux_ctr64 (
        .clk       (clk),
        .rst       (rst),
        .aux_addr  (aux_addr),
        .aux_rd    (aux_rd),
        .aux_wr    (aux_wr),
        .aux_wdata (aux_wdata),
        .exc_taken (exc_taken),
        .aux_rdata (aux_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: drive on the falling edge, sample 1 ns later, step the model on the rising edge.
    task automatic cyc(input logic [11:0] a, input logic rd, input logic wr,
                       input logic [31:0] wd, input logic ex, output logic [31:0] rv);
        @(negedge clk);
        aux_addr  = a;
        aux_rd    = rd;
        aux_wr    = wr;
        aux_wdata = wd;
        exc_taken = ex;
        #1 rv = aux_rdata;
        @(posedge clk);
        if (!rst) begin
            if (m_en) m_cnt = m_cnt + 1'b1;
            if (wr && a == A_CTRL) m_en = wd[0];
        end
        #1;
        aux_rd    = 1'b0;
        aux_wr    = 1'b0;
        exc_taken = 1'b0;
    endtask

    function automatic logic [31:0] lo_exp();
        return {{(32-TH){1'b0}}, m_cnt[TH-1:0]};
    endfunction

    function automatic logic [31:0] hi_exp();
        return {{(32-TH){1'b0}}, m_cnt[2*TH-1:TH]};
    endfunction

    task automatic idle(input int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) cyc(12'h0, 1'b0, 1'b0, 32'h0, 1'b0, d);
    endtask

    task automatic wait_no_carry();
        while (m_cnt[TH-1:0] > 4'd12) idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        logic [31:0] lo_v;
        logic [31:0] hi_v;
        logic [31:0] lo_e;
        logic [31:0] hi_e;
        logic [TH-1:0] hi_at_lo;
        logic good;

        // R1 reset state
        idle(3);
        rst = 1'b0;
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R1 ctrl", rv, 32'h0);
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv); check("R1 lo", rv, 32'h0);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv); check("R1 hi", rv, 32'h0);

        // R4 holds while disabled from reset
        idle(4);
        cyc(A_LO, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R4 lo after reset", rv, 32'h0);

        // R2 enable and readback; R3 counting
        cyc(A_CTRL, 1'b0, 1'b1, 32'h1, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R2 ctrl enable readback", rv, 32'h1);
        check("R3 first step", {24'h0, m_cnt}, 32'h1);
        idle(5);
        lo_e = lo_exp();
        cyc(A_LO, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R3 lo after run", rv, lo_e);
        hi_e = hi_exp();
        cyc(A_HI, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R3 hi after run", rv, hi_e);

        // Sweep: gap, exception position, counter phase (R8 R9 R10 R5)
        for (int s = 0; s < 64; s++) begin
            for (int g = 0; g < 3; g++) begin
                for (int e = 0; e <= g + 2; e++) begin
                    idle((s + g) % 3);
                    hi_at_lo = m_cnt[2*TH-1:TH];
                    lo_e = lo_exp();
                    cyc(A_LO, 1'b1, 1'b0, 32'h0, e == 0, lo_v);
                    check("R5 sweep lo", lo_v, lo_e);
                    for (int k = 1; k <= g; k++) begin
                        cyc(12'h0, 1'b0, 1'b0, 32'h0, e == k, rv);
                    end
                    hi_e = hi_exp();
                    cyc(A_HI, 1'b1, 1'b0, 32'h0, e == g + 1, hi_v);
                    check("R5 sweep hi", hi_v, hi_e);
                    good = (hi_e[TH-1:0] == hi_at_lo) && (e == g + 2);
                    cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv);
                    if (e != g + 2)
                        check("R9 exception in window", rv, 32'h1);
                    else if (!good)
                        check("R10 high moved", rv, 32'h1);
                    else
                        check("R8 clean pair", rv, 32'h8000_0001);
                end
            end
        end

        // R11 high read without low; control reads do not disturb
        wait_no_carry();
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R11 ctrl read mid-sequence", rv, 32'h8000_0001);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R11 lone high read", rv, 32'h1);

        // R7 low read clears status
        wait_no_carry();
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R7 setup pair", rv, 32'h8000_0001);
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R7 low read clears", rv, 32'h1);

        // R7 new low read discards earlier violation
        wait_no_carry();
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b1, rv);
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R7 restart discards violation", rv, 32'h8000_0001);

        // R6 writes to count halves ignored
        cyc(A_LO, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, rv);
        cyc(A_HI, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, rv);
        lo_e = lo_exp();
        cyc(A_LO, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R6 lo after write", rv, lo_e);
        hi_e = hi_exp();
        cyc(A_HI, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R6 hi after write", rv, hi_e);

        // R5 unmapped and no-strobe reads
        cyc(12'h106, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R5 unmapped", rv, 32'h0);
        cyc(A_LO,    1'b0, 1'b0, 32'h0, 1'b0, rv); check("R5 no strobe", rv, 32'h0);

        // R4 hold after disable; R2 readback of 0
        cyc(A_CTRL, 1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0, rv);
        lo_e = lo_exp();
        hi_e = hi_exp();
        idle(7);
        cyc(A_LO,   1'b1, 1'b0, 32'h0, 1'b0, rv); check("R4 lo held", rv, lo_e);
        cyc(A_HI,   1'b1, 1'b0, 32'h0, 1'b0, rv); check("R4 hi held", rv, hi_e);
        cyc(A_CTRL, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R2 ctrl disabled readback", rv, 32'h8000_0000);

        // R3 wrap of the full count
        cyc(A_CTRL, 1'b0, 1'b1, 32'h1, 1'b0, rv);
        idle(300);
        lo_e = lo_exp();
        cyc(A_LO, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R3 lo after wrap", rv, lo_e);
        hi_e = hi_exp();
        cyc(A_HI, 1'b1, 1'b0, 32'h0, 1'b0, rv); check("R3 hi after wrap", rv, hi_e);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule